// File: doc/BRIEF.md
# Load/Store Request Initiator

This block is the requesting end of a handshaked load/store port. A local controller hands it one command at a time. Each command carries the operation kind, a target address and, for a store, the data to write. The block latches the command and raises the matching request line together with the address-valid flag and the address. It then waits until the responder either accepts or rejects the address. After acceptance, a store fires its data strobe for one cycle. A load waits for the load-valid pulse and captures the returned data on that cycle.

When a transaction ends, the block drops every port line and gives the controller a one-cycle done pulse. A status bit with the pulse separates a normal finish from an address exception. An abort input cancels whatever is in flight and returns the block to idle. Data and address widths are parameters, 64 and 48 bits by default.

Top module: `ldst_initiator`

## Requirements
- R1: After reset, the load request, store request, address-valid, store-valid and done outputs are low, and `resultData` is zero.
- R2: A command is taken only on a cycle where `cmdValid` and `cmdReady` are both high. From the next cycle, exactly one request line is high: `portStReq` when `cmdIsStore` was 1, otherwise `portLdReq`. `portAddrValid` rises in the same cycle. The two request lines are never high together.
- R3: While `portAddrValid` stays high, `portAddr` holds the latched command address unchanged.
- R4: If `portAddrExc` is seen while the address is awaiting acceptance, the next cycle has all port lines low, `doneOut` high and `doneErr` = 1.
- R5: For a store, `portAddrAck` while awaiting acceptance causes `portStValid` to be high in the next cycle only, with `portStData` equal to the command data. The cycle after that has all port lines low and `doneOut` high with `doneErr` = 0.
- R6: For a load whose address has been accepted, a `portLdValid` cycle loads `portLdData` into `resultData`. The next cycle has all port lines low and `doneOut` high with `doneErr` = 0. `resultData` keeps that value until the next successful load.
- R7: `portStValid` never rises unless `portAddrAck` was high in the previous cycle. A `portLdValid` pulse while the address is still awaiting acceptance is ignored.
- R8: When `abortReq` is high at a clock edge, every port line and `doneOut` are low from the next cycle, and the block is idle. An abort while idle has no visible effect; it also blocks a command offered in the same cycle.
- R9: `doneOut` is high for exactly one cycle per finished transaction. `cmdReady` returns in the cycle after the done pulse.
- R10: `cmdReady` is high only when the block is idle and `portBusy` is low. A `cmdValid` offered while `cmdReady` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Controller offers a command |
| cmdIsStore | input | 1 | 1 = store, 0 = load |
| cmdAddr | input | AW | Command address |
| cmdData | input | DW | Store data |
| cmdReady | output | 1 | Block can take a command this cycle |
| abortReq | input | 1 | Cancel the transaction in flight |
| doneOut | output | 1 | One-cycle transaction finish pulse |
| doneErr | output | 1 | With doneOut: 1 = address exception |
| resultData | output | DW | Data of the last successful load |
| portLdReq | output | 1 | Load request line |
| portStReq | output | 1 | Store request line |
| portBusy | input | 1 | Responder busy; blocks new commands |
| portAddrValid | output | 1 | Address valid flag |
| portAddr | output | AW | Address to responder |
| portAddrAck | input | 1 | Address accepted pulse |
| portAddrExc | input | 1 | Address exception pulse |
| portStValid | output | 1 | Store data strobe |
| portStData | output | DW | Store data to responder |
| portLdValid | input | 1 | Load data valid pulse |
| portLdData | input | DW | Load data from responder |

## Verification
On every cycle, the properties check the protocol invariants. The request lines are mutually exclusive and the address stays stable while valid. The store strobe lasts one cycle and follows an acceptance. The done pulse lasts one cycle, and an error status traces back to an exception. An abort clears the port, and ready is never offered while busy or active. The end-to-end sequences can only be shown by the bench's scenarios and its reference model: the exact cycle in which each completion kind releases the lines, the captured load value and how long it persists, ignoring a premature load-valid, and blocking commands under busy or abort.

// File: rtl/ldst_init_pkg.sv
package ldst_init_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_FIRE  = 3'd2,
    ST_LOAD  = 3'd3,
    ST_DONE  = 3'd4
  } initState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCmd;
    logic captureLoad;
    logic markExc;
    logic markOk;
  } ctrlStrobes_t;

endpackage

// File: rtl/ldst_init_ctrl.sv
module ldst_init_ctrl
  import ldst_init_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic         abortReq,
  input  logic         portBusy,
  input  logic         portAddrAck,
  input  logic         portAddrExc,
  input  logic         portLdValid,
  input  logic         isStore,
  output ctrlStrobes_t strobes,
  output logic         reqActive,
  output logic         stFire,
  output logic         doneOut,
  output logic         cmdReady
);

  initState_e stateQ, stateD;
  logic accept;

  assign cmdReady  = (stateQ == ST_IDLE) && !portBusy;
  assign accept    = cmdReady && cmdValid && !abortReq;
  assign reqActive = (stateQ == ST_ADDR) || (stateQ == ST_FIRE) || (stateQ == ST_LOAD);
  assign stFire    = (stateQ == ST_FIRE);
  assign doneOut   = (stateQ == ST_DONE);

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    if (abortReq) begin
      stateD = ST_IDLE;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (accept) begin
            stateD           = ST_ADDR;
            strobes.latchCmd = 1'b1;
          end
        end
        ST_ADDR: begin
          if (portAddrExc) begin
            stateD          = ST_DONE;
            strobes.markExc = 1'b1;
          end else if (portAddrAck) begin
            stateD = isStore ? ST_FIRE : ST_LOAD;
          end
        end
        ST_FIRE: begin
          stateD         = ST_DONE;
          strobes.markOk = 1'b1;
        end
        ST_LOAD: begin
          if (portLdValid) begin
            stateD              = ST_DONE;
            strobes.captureLoad = 1'b1;
            strobes.markOk      = 1'b1;
          end
        end
        ST_DONE: stateD = ST_IDLE;
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/ldst_init_datapath.sv
module ldst_init_datapath
  import ldst_init_pkg::*;
#(
  parameter int DW = 64,
  parameter int AW = 48
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  strobes,
  input  logic          cmdIsStore,
  input  logic [AW-1:0] cmdAddr,
  input  logic [DW-1:0] cmdData,
  input  logic [DW-1:0] portLdData,
  output logic          isStore,
  output logic [AW-1:0] addrQ,
  output logic [DW-1:0] stDataQ,
  output logic [DW-1:0] resultQ,
  output logic          errQ
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isStore <= 1'b0;
      addrQ   <= '0;
      stDataQ <= '0;
    end else if (strobes.latchCmd) begin
      isStore <= cmdIsStore;
      addrQ   <= cmdAddr;
      stDataQ <= cmdData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    resultQ <= '0;
    else if (strobes.captureLoad) resultQ <= portLdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                errQ <= 1'b0;
    else if (strobes.markExc) errQ <= 1'b1;
    else if (strobes.markOk)  errQ <= 1'b0;
  end

endmodule

// File: rtl/ldst_initiator.sv
module ldst_initiator
  import ldst_init_pkg::*;
#(
  parameter int DW = 64,
  parameter int AW = 48
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic          cmdIsStore,
  input  logic [AW-1:0] cmdAddr,
  input  logic [DW-1:0] cmdData,
  output logic          cmdReady,
  input  logic          abortReq,
  output logic          doneOut,
  output logic          doneErr,
  output logic [DW-1:0] resultData,
  output logic          portLdReq,
  output logic          portStReq,
  input  logic          portBusy,
  output logic          portAddrValid,
  output logic [AW-1:0] portAddr,
  input  logic          portAddrAck,
  input  logic          portAddrExc,
  output logic          portStValid,
  output logic [DW-1:0] portStData,
  input  logic          portLdValid,
  input  logic [DW-1:0] portLdData
);

  ctrlStrobes_t strobes;
  logic reqActive;
  logic isStore;

  ldst_init_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdValid    (cmdValid),
    .abortReq    (abortReq),
    .portBusy    (portBusy),
    .portAddrAck (portAddrAck),
    .portAddrExc (portAddrExc),
    .portLdValid (portLdValid),
    .isStore     (isStore),
    .strobes     (strobes),
    .reqActive   (reqActive),
    .stFire      (portStValid),
    .doneOut     (doneOut),
    .cmdReady    (cmdReady)
  );

  ldst_init_datapath #(.DW(DW), .AW(AW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cmdIsStore (cmdIsStore),
    .cmdAddr    (cmdAddr),
    .cmdData    (cmdData),
    .portLdData (portLdData),
    .isStore    (isStore),
    .addrQ      (portAddr),
    .stDataQ    (portStData),
    .resultQ    (resultData),
    .errQ       (doneErr)
  );

  assign portAddrValid = reqActive;
  assign portLdReq     = reqActive && !isStore;
  assign portStReq     = reqActive && isStore;

endmodule

// File: rtl/ldst_initiator_chk.sv
module ldst_initiator_chk #(
  parameter int DW = 64,
  parameter int AW = 48
) (
  input logic          clk,
  input logic          rstN,
  input logic          abortReq,
  input logic          cmdReady,
  input logic          portBusy,
  input logic          doneOut,
  input logic          doneErr,
  input logic          portLdReq,
  input logic          portStReq,
  input logic          portAddrValid,
  input logic [AW-1:0] portAddr,
  input logic          portAddrAck,
  input logic          portAddrExc,
  input logic          portStValid
);

  a_r2_one_request: assert property (@(posedge clk) disable iff (!rstN)
    !(portLdReq && portStReq));

  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (portAddrValid && $past(portAddrValid)) |-> $stable(portAddr));

  a_r4_err_from_exc: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && doneErr) |-> $past(portAddrExc));

  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    portStValid |=> !portStValid);

  a_r7_strobe_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    $rose(portStValid) |-> $past(portAddrAck));

  a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> (!portAddrValid && !portStValid && !doneOut));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (!portBusy && !portAddrValid && !doneOut));

endmodule

bind ldst_initiator ldst_initiator_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .abortReq      (abortReq),
  .cmdReady      (cmdReady),
  .portBusy      (portBusy),
  .doneOut       (doneOut),
  .doneErr       (doneErr),
  .portLdReq     (portLdReq),
  .portStReq     (portStReq),
  .portAddrValid (portAddrValid),
  .portAddr      (portAddr),
  .portAddrAck   (portAddrAck),
  .portAddrExc   (portAddrExc),
  .portStValid   (portStValid)
);

// File: tb/ldst_initiator_tb.sv
module ldst_initiator_tb;
  localparam int DW = 64;
  localparam int AW = 48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 0, cmdIsStore = 0, abortReq = 0, portBusy = 0;
  logic portAddrAck = 0, portAddrExc = 0, portLdValid = 0;
  logic [AW-1:0] cmdAddr = '0;
  logic [DW-1:0] cmdData = '0, portLdData = '0;
  logic cmdReady, doneOut, doneErr, portLdReq, portStReq, portAddrValid, portStValid;
  logic [AW-1:0] portAddr;
  logic [DW-1:0] resultData, portStData;

  int vectors = 0;
  int misses = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  ldst_initiator #(.DW(DW), .AW(AW)) u_dut (.*);

  // behavioural reference model
  bit mBusy, mSt, mAcked, mFire, mDone, mErr;
  logic [AW-1:0] mAddr;
  logic [DW-1:0] mData, mResult;

  always @(posedge clk) begin
    bit wasDone;
    cycles++;
    if (!rstN) begin
      mBusy = 0; mSt = 0; mAcked = 0; mFire = 0; mDone = 0; mErr = 0;
      mAddr = '0; mData = '0; mResult = '0;
    end else begin
      wasDone = mDone;
      mDone = 0;
      if (abortReq) begin
        mBusy = 0; mFire = 0; mAcked = 0;
      end else if (!mBusy && !wasDone) begin
        if (cmdValid && !portBusy) begin
          mBusy = 1; mSt = cmdIsStore; mAddr = cmdAddr; mData = cmdData; mAcked = 0;
        end
      end else if (mBusy) begin
        if (mFire) begin
          mFire = 0; mBusy = 0; mDone = 1; mErr = 0;
        end else if (!mAcked) begin
          if (portAddrExc) begin
            mBusy = 0; mDone = 1; mErr = 1;
          end else if (portAddrAck) begin
            mAcked = 1;
            if (mSt) mFire = 1;
          end
        end else if (portLdValid) begin
          mResult = portLdData; mBusy = 0; mDone = 1; mErr = 0;
        end
      end
    end
  end

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // compare every clock, 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (rstN) begin
      chk("R2 portLdReq", DW'(portLdReq), DW'(mBusy && !mSt));
      chk("R2 portStReq", DW'(portStReq), DW'(mBusy && mSt));
      chk("R2 R8 portAddrValid", DW'(portAddrValid), DW'(mBusy));
      if (mBusy) chk("R3 portAddr", DW'(portAddr), DW'(mAddr));
      chk("R5 R7 portStValid", DW'(portStValid), DW'(mFire));
      if (mFire) chk("R5 portStData", portStData, mData);
      chk("R9 doneOut", DW'(doneOut), DW'(mDone));
      if (mDone) chk("R4 doneErr", DW'(doneErr), DW'(mErr));
      chk("R6 R7 resultData", resultData, mResult);
      chk("R10 cmdReady", DW'(cmdReady), DW'(!mBusy && !mDone && !portBusy));
    end
  end

  task automatic offer(bit st, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdValid = 1; cmdIsStore = st; cmdAddr = a; cmdData = d;
    @(negedge clk);
    cmdValid = 0;
  endtask

  task automatic pulseAck(int waitN);
    repeat (waitN) @(negedge clk);
    portAddrAck = 1; @(negedge clk); portAddrAck = 0;
  endtask

  task automatic pulseExc(int waitN);
    repeat (waitN) @(negedge clk);
    portAddrExc = 1; @(negedge clk); portAddrExc = 0;
  endtask

  task automatic pulseLd(int waitN, logic [DW-1:0] d);
    repeat (waitN) @(negedge clk);
    portLdValid = 1; portLdData = d; @(negedge clk); portLdValid = 0; portLdData = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    vectors++;
    if (portLdReq || portStReq || portAddrValid || portStValid || doneOut || resultData !== '0) begin
      misses++;
      $display("FAIL R1 reset outputs act=%b%b%b%b%b exp=00000", portLdReq, portStReq,
               portAddrValid, portStValid, doneOut);
    end
    // store, acceptance after two cycles
    offer(1, 48'h0000_1234_5678, 64'hdead_beef_0000_0001);
    pulseAck(2);
    repeat (4) @(negedge clk);
    // load, immediate accept, data after 3 cycles
    offer(0, 48'h0000_0000_0040, '0);
    pulseAck(0);
    pulseLd(3, 64'h0123_4567_89ab_cdef);
    repeat (3) @(negedge clk);
    // load with exception (R4)
    offer(0, 48'hffff_ffff_fff0, '0);
    pulseExc(1);
    repeat (3) @(negedge clk);
    // store with exception
    offer(1, 48'h0000_0000_0100, 64'h5555_aaaa_5555_aaaa);
    pulseExc(0);
    repeat (3) @(negedge clk);
    // R7 early load-valid ignored, then proper completion
    offer(0, 48'h0000_0000_0200, '0);
    pulseLd(1, 64'hbad0_bad0_bad0_bad0);
    pulseAck(1);
    pulseLd(2, 64'h0f0f_0f0f_0f0f_0f0f);
    repeat (3) @(negedge clk);
    // R8 abort while awaiting acceptance
    offer(1, 48'h0000_0000_0300, 64'h1);
    repeat (2) @(negedge clk);
    abortReq = 1; @(negedge clk); abortReq = 0;
    pulseAck(1);   // stray acceptance after abort must do nothing
    repeat (2) @(negedge clk);
    // R8 abort while waiting for load data
    offer(0, 48'h0000_0000_0400, '0);
    pulseAck(0);
    abortReq = 1; @(negedge clk); abortReq = 0;
    pulseLd(0, 64'hcccc_cccc_cccc_cccc);
    repeat (2) @(negedge clk);
    // R8 abort while idle, also blocking a same-cycle command
    abortReq = 1; cmdValid = 1; cmdIsStore = 1; cmdAddr = 48'h777; cmdData = 64'h7;
    @(negedge clk); abortReq = 0; cmdValid = 0;
    repeat (2) @(negedge clk);
    // R10 command under busy ignored, then taken when busy drops
    portBusy = 1; cmdValid = 1; cmdIsStore = 0; cmdAddr = 48'h880;
    repeat (3) @(negedge clk);
    portBusy = 0;
    @(negedge clk); cmdValid = 0;
    pulseAck(0);
    pulseLd(0, 64'h8888_0000_8888_0000);
    // back-to-back store then load
    offer(1, 48'h0000_0000_0990, 64'h9999);
    pulseAck(0);
    offer(0, 48'h0000_0000_0990, '0);
    pulseAck(1);
    pulseLd(1, 64'h9999);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #200000;
    misses++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule